// File: doc/BRIEF.md
# Reachable-State Equivalence Checker for Two Transition Tables

The block decides whether two small synchronous state machines behave alike when started from the same state. Each machine is held as a next-state table, with one entry for each pair of input word and current state. Both tables sit in internal register arrays. Software or a loader fills them through a single write port while the block is idle. A start pulse then launches a breadth-first walk from a common initial state.

The walk keeps a visited vector and a first-in first-out worklist of states. Each state that is reached for the first time enters the worklist exactly once. When a state leaves the worklist, every input word is applied to it in turn and the two tables' entries for that pair are compared. States that the walk never reaches are never looked at, so the two tables may differ in those rows without any effect on the result. The walk stops early at the first disagreeing pair and reports that pair. If no pair disagrees, the walk ends when the worklist is empty. In both cases a done flag and an equivalence flag are raised, and they hold until the next start.

The number of input words and the number of states are parameters, and neither has to be a power of two. Codes at or above those counts are treated as unused.

Top module: `reach_equiv_top`

## Requirements
- R1: After reset, busy, done and equiv are all 0, and every entry of both tables holds state code 0.
- R2: A start pulse while idle raises busy on the next cycle and clears done, equiv, bad_in and bad_st to 0. A start pulse while busy has no effect on the run.
- R3: The walk begins at state INIT_ST. States are expanded in the order in which they were first reached, and for each expanded state the inputs are applied in ascending order 0 to NUM_IN-1. A run that finds no mismatch raises done exactly R*(NUM_IN+1)+1 clock edges after the edge that samples start, where R is the number of reachable states. busy falls on that same edge.
- R4: Each reachable state is placed in the worklist exactly once, so a worklist of NUM_ST entries never overflows.
- R5: equiv is 1 at done when the two tables agree on every input for every reachable state. Entries in unreachable rows do not affect the result.
- R6: At the first pair (in the order of R3) where the tables disagree, the walk stops: done=1, equiv=0, bad_in is that input code and bad_st is that state code.
- R7: A write with wr_en=1 stores wr_next at (wr_in, wr_st) in table A when wr_sel=0 and in table B when wr_sel=1. The write is dropped if wr_in>=NUM_IN, wr_st>=NUM_ST or wr_next>=NUM_ST.
- R8: Table writes presented while busy is 1 are dropped. The tables keep their contents, which a later run shows.
- R9: With both tables in their reset state and INIT_ST not 0, the walk reaches exactly two states and reports them equivalent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | Table select: 0 selects table A, 1 selects table B |
| wr_in | input | IW | Input word index of the entry being written |
| wr_st | input | SW | Current-state index of the entry being written |
| wr_next | input | SW | Next-state code to store |
| start | input | 1 | Pulse that launches a walk |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | The last walk has finished |
| equiv | output | 1 | The last walk found no mismatch |
| bad_in | output | IW | Input code of the reported mismatch |
| bad_st | output | SW | State code of the reported mismatch |

## Verification
The bench builds the block with NUM_IN=3, NUM_ST=6 and INIT_ST=2. These values leave codes in both index widths that fall outside the valid range, so out-of-range writes can be presented. They also keep a full table at 18 entries, which allows a sweep that corrupts every entry of a partly reachable machine one at a time. Each corrupted reachable entry must be reported exactly, and each corrupted unreachable entry must be ignored. The small size also lets the bench check the walk length exactly for several reachable-set sizes: one state, two states, four states and all six.

// File: rtl/reach_equiv_pkg.sv
package reach_equiv_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_POP  = 2'd1,
    PH_SCAN = 2'd2
  } walk_phase_t;

  // index width for n codes, at least one bit
  function automatic int bits_for(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/nxt_table.sv
module nxt_table #(
  parameter  int NUM_IN = 3,
  parameter  int NUM_ST = 6,
  localparam int IW     = reach_equiv_pkg::bits_for(NUM_IN),
  localparam int SW     = reach_equiv_pkg::bits_for(NUM_ST)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic          hold_i,
  input  logic [IW-1:0] wr_in_i,
  input  logic [SW-1:0] wr_st_i,
  input  logic [SW-1:0] wr_next_i,
  input  logic [IW-1:0] rd_in_i,
  input  logic [SW-1:0] rd_st_i,
  output logic [SW-1:0] rd_next_o
);

  localparam int ENTRIES = NUM_IN * NUM_ST;
  localparam int MW      = ENTRIES * SW;

  logic [MW-1:0] mem_q;
  logic [MW-1:0] mem_d;
  logic          wr_ok;
  int            widx;
  int            ridx;

  // write qualification and next contents
  always_comb begin
    wr_ok = wr_en_i && !hold_i
            && (int'(wr_in_i)   < NUM_IN)
            && (int'(wr_st_i)   < NUM_ST)
            && (int'(wr_next_i) < NUM_ST);
    widx  = int'(wr_in_i) * NUM_ST + int'(wr_st_i);
    mem_d = mem_q;
    if (wr_ok) begin
      mem_d[widx*SW +: SW] = wr_next_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (wr_ok) begin
      mem_q <= mem_d;
    end
  end

  // read port
  always_comb begin
    ridx = int'(rd_in_i) * NUM_ST + int'(rd_st_i);
    if (ridx < ENTRIES) begin
      rd_next_o = mem_q[ridx*SW +: SW];
    end else begin
      rd_next_o = '0;
    end
  end

  // writes during a walk leave the contents untouched
  assert_hold_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && hold_i) |=> $stable(mem_q));

  // stored codes always name a real state
  assert_entry_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd_next_o) < NUM_ST);

endmodule

// File: rtl/bfs_queue.sv
module bfs_queue #(
  parameter  int DEPTH = 6,
  parameter  int W     = 3,
  localparam int PW    = reach_equiv_pkg::bits_for(DEPTH),
  localparam int CW    = reach_equiv_pkg::bits_for(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o
);

  logic [DEPTH*W-1:0] store_q, store_d;
  logic [PW-1:0]      rd_ptr_q, rd_ptr_d, wr_ptr_q, wr_ptr_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [PW-1:0]      rp, wp;
  logic [CW-1:0]      cbase;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rp      = clr_i ? '0 : rd_ptr_q;
    wp      = clr_i ? '0 : wr_ptr_q;
    cbase   = clr_i ? '0 : cnt_q;
    store_d = store_q;
    if (push_i) begin
      store_d[int'(wp)*W +: W] = push_data_i;
    end
    wr_ptr_d = push_i ? ptr_inc(wp) : wp;
    rd_ptr_d = pop_i  ? ptr_inc(rp) : rp;
    cnt_d    = cbase + CW'(push_i) - CW'(pop_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q  <= '0;
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) begin
        store_q <= store_d;
      end
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  assign head_o  = store_q[int'(rd_ptr_q)*W +: W];
  assign empty_o = (cnt_q == '0);

  // a state is queued once, so DEPTH=NUM_ST never fills past capacity
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !clr_i) |-> (cnt_q != CW'(DEPTH)));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);

endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import reach_equiv_pkg::*;
#(
  parameter  int NUM_IN  = 3,
  parameter  int NUM_ST  = 6,
  parameter  int INIT_ST = 0,
  localparam int IW      = reach_equiv_pkg::bits_for(NUM_IN),
  localparam int SW      = reach_equiv_pkg::bits_for(NUM_ST)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [SW-1:0] next_a_i,
  input  logic [SW-1:0] next_b_i,
  input  logic          q_empty_i,
  input  logic [SW-1:0] q_head_i,
  output logic [IW-1:0] rd_in_o,
  output logic [SW-1:0] rd_st_o,
  output logic          q_clr_o,
  output logic          q_push_o,
  output logic [SW-1:0] q_push_data_o,
  output logic          q_pop_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          equiv_o,
  output logic [IW-1:0] bad_in_o,
  output logic [SW-1:0] bad_st_o
);

  walk_phase_t       phase_q, phase_d;
  logic [SW-1:0]     cur_q, cur_d;
  logic [IW-1:0]     inp_q, inp_d;
  logic [NUM_ST-1:0] visited_q, visited_d;
  logic              done_q, done_d;
  logic              equiv_q, equiv_d;
  logic [IW-1:0]     bad_in_q, bad_in_d;
  logic [SW-1:0]     bad_st_q, bad_st_d;

  always_comb begin
    phase_d       = phase_q;
    cur_d         = cur_q;
    inp_d         = inp_q;
    visited_d     = visited_q;
    done_d        = done_q;
    equiv_d       = equiv_q;
    bad_in_d      = bad_in_q;
    bad_st_d      = bad_st_q;
    q_clr_o       = 1'b0;
    q_push_o      = 1'b0;
    q_push_data_o = next_a_i;
    q_pop_o       = 1'b0;

    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          visited_d          = '0;
          visited_d[INIT_ST] = 1'b1;
          q_clr_o            = 1'b1;
          q_push_o           = 1'b1;
          q_push_data_o      = SW'(INIT_ST);
          done_d             = 1'b0;
          equiv_d            = 1'b0;
          bad_in_d           = '0;
          bad_st_d           = '0;
          phase_d            = PH_POP;
        end
      end
      PH_POP: begin
        if (q_empty_i) begin
          done_d  = 1'b1;
          equiv_d = 1'b1;
          phase_d = PH_IDLE;
        end else begin
          cur_d   = q_head_i;
          q_pop_o = 1'b1;
          inp_d   = '0;
          phase_d = PH_SCAN;
        end
      end
      PH_SCAN: begin
        if (next_a_i != next_b_i) begin
          done_d   = 1'b1;
          equiv_d  = 1'b0;
          bad_in_d = inp_q;
          bad_st_d = cur_q;
          phase_d  = PH_IDLE;
        end else begin
          if (!visited_q[int'(next_a_i)]) begin
            visited_d[int'(next_a_i)] = 1'b1;
            q_push_o                  = 1'b1;
          end
          if (inp_q == IW'(NUM_IN - 1)) begin
            phase_d = PH_POP;
          end else begin
            inp_d = inp_q + 1'b1;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cur_q     <= '0;
      inp_q     <= '0;
      visited_q <= '0;
      done_q    <= 1'b0;
      equiv_q   <= 1'b0;
      bad_in_q  <= '0;
      bad_st_q  <= '0;
    end else begin
      phase_q   <= phase_d;
      cur_q     <= cur_d;
      inp_q     <= inp_d;
      visited_q <= visited_d;
      done_q    <= done_d;
      equiv_q   <= equiv_d;
      bad_in_q  <= bad_in_d;
      bad_st_q  <= bad_st_d;
    end
  end

  assign rd_in_o  = inp_q;
  assign rd_st_o  = cur_q;
  assign busy_o   = (phase_q != PH_IDLE);
  assign done_o   = done_q;
  assign equiv_o  = equiv_q;
  assign bad_in_o = bad_in_q;
  assign bad_st_o = bad_st_q;

  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_stop_on_diff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SCAN && next_a_i != next_b_i) |=> (done_o && !equiv_o));

  assert_report_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !equiv_o) |-> (int'(bad_in_o) < NUM_IN && int'(bad_st_o) < NUM_ST));

endmodule

// File: rtl/reach_equiv_top.sv
module reach_equiv_top #(
  parameter  int NUM_IN  = 3,
  parameter  int NUM_ST  = 6,
  parameter  int INIT_ST = 0,
  localparam int IW      = reach_equiv_pkg::bits_for(NUM_IN),
  localparam int SW      = reach_equiv_pkg::bits_for(NUM_ST)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [IW-1:0] wr_in,
  input  logic [SW-1:0] wr_st,
  input  logic [SW-1:0] wr_next,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          equiv,
  output logic [IW-1:0] bad_in,
  output logic [SW-1:0] bad_st
);

  logic [IW-1:0] rd_in;
  logic [SW-1:0] rd_st;
  logic [SW-1:0] next_ab [2];
  logic          q_clr, q_push, q_pop, q_empty;
  logic [SW-1:0] q_push_data, q_head;

  // one table per machine, selected by wr_sel
  for (genvar g = 0; g < 2; g++) begin : g_tab
    nxt_table #(
      .NUM_IN (NUM_IN),
      .NUM_ST (NUM_ST)
    ) u_tab (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en && (wr_sel == 1'(g))),
      .hold_i    (busy),
      .wr_in_i   (wr_in),
      .wr_st_i   (wr_st),
      .wr_next_i (wr_next),
      .rd_in_i   (rd_in),
      .rd_st_i   (rd_st),
      .rd_next_o (next_ab[g])
    );
  end

  bfs_queue #(
    .DEPTH (NUM_ST),
    .W     (SW)
  ) u_queue (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (q_clr),
    .push_i      (q_push),
    .push_data_i (q_push_data),
    .pop_i       (q_pop),
    .head_o      (q_head),
    .empty_o     (q_empty)
  );

  walk_ctrl #(
    .NUM_IN  (NUM_IN),
    .NUM_ST  (NUM_ST),
    .INIT_ST (INIT_ST)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .next_a_i      (next_ab[0]),
    .next_b_i      (next_ab[1]),
    .q_empty_i     (q_empty),
    .q_head_i      (q_head),
    .rd_in_o       (rd_in),
    .rd_st_o       (rd_st),
    .q_clr_o       (q_clr),
    .q_push_o      (q_push),
    .q_push_data_o (q_push_data),
    .q_pop_o       (q_pop),
    .busy_o        (busy),
    .done_o        (done),
    .equiv_o       (equiv),
    .bad_in_o      (bad_in),
    .bad_st_o      (bad_st)
  );

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !done && !equiv));

endmodule

// File: tb/sim_reach_equiv_top.sv
module sim_reach_equiv_top;

  localparam int M  = 3;
  localparam int N  = 6;
  localparam int S0 = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_sel, start;
  logic [1:0] wr_in;
  logic [2:0] wr_st, wr_next;
  logic       busy, done, equiv;
  logic [1:0] bad_in;
  logic [2:0] bad_st;

  int checks = 0;
  int fails  = 0;
  int ta [M*N];
  int tb [M*N];

  always #5 clk = ~clk;

  reach_equiv_top #(.NUM_IN(M), .NUM_ST(N), .INIT_ST(S0)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_in(wr_in), .wr_st(wr_st), .wr_next(wr_next), .start(start),
    .busy(busy), .done(done), .equiv(equiv), .bad_in(bad_in), .bad_st(bad_st)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one port write, starting and ending at a falling edge
  task automatic wr(input int sel, input int i, input int s, input int n);
    wr_en   = 1'b1;
    wr_sel  = 1'(sel);
    wr_in   = 2'(i);
    wr_st   = 3'(s);
    wr_next = 3'(n);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic load_all();
    for (int i = 0; i < M; i++) begin
      for (int s = 0; s < N; s++) begin
        wr(0, i, s, ta[i*N+s]);
        wr(1, i, s, tb[i*N+s]);
      end
    end
  endtask

  // breadth-first reference walk from the requirements
  task automatic model(output int r, output bit eq, output int bi, output int bs);
    int q [N];
    bit vis [N];
    int hd, tl, s, nx;
    for (int k = 0; k < N; k++) vis[k] = 1'b0;
    hd = 0; tl = 0; eq = 1'b1; bi = 0; bs = 0;
    q[tl] = S0; tl++; vis[S0] = 1'b1;
    while (hd < tl && eq) begin
      s = q[hd]; hd++;
      for (int i = 0; i < M; i++) begin
        if (eq) begin
          nx = ta[i*N+s];
          if (nx != tb[i*N+s]) begin
            eq = 1'b0; bi = i; bs = s;
          end else if (!vis[nx]) begin
            vis[nx] = 1'b1; q[tl] = nx; tl++;
          end
        end
      end
    end
    r = tl;
  endtask

  // inject: 0 none, 1 extra start mid-run, 2 table write mid-run
  task automatic run(input string tag, input int inject);
    int e, r, bi, bs;
    bit eq;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    chk(done == 1'b0 && equiv == 1'b0 && bad_in == 2'd0 && bad_st == 3'd0,
        "R2 flags cleared", int'({done, equiv}), 0);
    e = 0;
    while (!done && e < 500) begin
      if (e == 3 && inject == 1) start = 1'b1;
      if (e == 3 && inject == 2) begin
        wr_en = 1'b1; wr_sel = 1'b1; wr_in = 2'd0; wr_st = 3'(S0);
        wr_next = 3'((tb[S0] + 1) % N);
      end
      @(negedge clk);
      start = 1'b0;
      wr_en = 1'b0;
      e++;
    end
    model(r, eq, bi, bs);
    chk(done == 1'b1, {tag, " done"}, int'(done), 1);
    chk(equiv == eq, {tag, " equiv"}, int'(equiv), int'(eq));
    chk(busy == 1'b0, {tag, " busy low"}, int'(busy), 0);
    if (eq) begin
      chk(e == r*(M+1)+1, {tag, " R3 R4 walk length"}, e, r*(M+1)+1);
    end else begin
      chk(int'(bad_in) == bi, {tag, " R6 bad_in"}, int'(bad_in), bi);
      chk(int'(bad_st) == bs, {tag, " R6 bad_st"}, int'(bad_st), bs);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int old;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; start = 1'b0;
    wr_in = '0; wr_st = '0; wr_next = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !equiv, "R1 reset state", int'({busy, done, equiv}), 0);

    // R9: reset tables all zero, two reachable states
    for (int k = 0; k < M*N; k++) begin ta[k] = 0; tb[k] = 0; end
    run("R9 R1 reset tables", 0);

    // full reachability: next = (2s+i) mod N
    for (int i = 0; i < M; i++)
      for (int s = 0; s < N; s++) begin
        ta[i*N+s] = (2*s + i) % N; tb[i*N+s] = ta[i*N+s];
      end
    load_all();
    run("R3 R5 full walk", 0);
    run("R2 start while busy", 1);
    run("R8 write while busy", 2);
    run("R8 rerun after dropped write", 0);

    // R7: out-of-range writes dropped
    wr(0, 0, S0, 6);
    wr(0, 3, S0, 1);
    wr(0, 0, 7, 1);
    run("R7 out-of-range writes", 0);
    // R7: valid write lands in table B
    old = tb[0*N+S0];
    tb[0*N+S0] = (old + 1) % N;
    wr(1, 0, S0, tb[0*N+S0]);
    run("R7 valid write", 0);
    tb[0*N+S0] = old;
    wr(1, 0, S0, old);

    // single self-loop state
    for (int i = 0; i < M; i++)
      for (int s = 0; s < N; s++) begin
        ta[i*N+s] = s; tb[i*N+s] = s;
      end
    load_all();
    run("R3 self loop", 0);

    // states 0..3 reachable, rows 4 and 5 differ between machines
    for (int i = 0; i < M; i++)
      for (int s = 0; s < N; s++) begin
        ta[i*N+s] = (s < 4) ? (s + i + 1) % 4 : 5;
        tb[i*N+s] = (s < 4) ? ta[i*N+s] : (i + s) % N;
      end
    load_all();
    run("R5 unreachable rows differ", 0);

    // sweep: corrupt each entry of B in turn
    for (int i = 0; i < M; i++)
      for (int s = 0; s < N; s++) begin
        old = tb[i*N+s];
        tb[i*N+s] = (old + 1) % N;
        wr(1, i, s, tb[i*N+s]);
        if (s < 4) run("R6 reachable corruption", 0);
        else       run("R5 unreachable corruption", 0);
        tb[i*N+s] = old;
        wr(1, i, s, old);
      end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule